// File: doc/BRIEF.md
# BCD Stopwatch Timer with Interrupts

This block counts hundredths and tenths of a second in packed BCD, driven by a one-cycle tick pulse that arrives at 100 Hz. Software reads both digits as one byte. The chain of digits produces three event rates: 100 Hz on every tick, 10 Hz when the hundredths digit wraps, and 1 Hz when the tenths digit wraps. Each rate has its own sticky flag and its own enable bit.

A byte-wide register bus gives access to the count, mask and flag registers. Reads are combinational. Writes take effect at the next clock edge. The interrupt output is asserted while any flag is set together with its enable bit. A synchronous clear input returns the count to zero and leaves the flags as they are.

Top module: `swt_stopwatch`

## Requirements
- R1: Address 0 reads the count byte, with the tenths digit in bits 7:4 and the hundredths digit in bits 3:0. Each digit stays within 0..9, and both reset to 0.
- R2: Each accepted tick advances the hundredths digit by one. When hundredths goes from 9 to 0, tenths advances by one. Tenths goes from 9 to 0 in the same way. The new count can be read in the cycle after the tick edge.
- R3: A write to address 0 has no effect on the count.
- R4: Address 1 is the mask register. Bit 2 enables the 1 Hz event, bit 1 the 10 Hz event and bit 0 the 100 Hz event, with 1 meaning enabled. The mask resets to 0, and bits 7:3 always read 0. Address 3 always reads 0.
- R5: Address 2 is the flag register, using the same bit positions as the mask, and it resets to 0. Bit 0 is set by every accepted tick. Bit 1 is set when hundredths wraps. Bit 2 is set when tenths wraps. Flags are set whether or not they are enabled, and bits 7:3 read 0.
- R6: Writing 1 to a flag bit clears that flag at the next edge. Writing 0 to a flag bit leaves it unchanged.
- R7: If an event and a write-one clear reach the same flag in the same cycle, the flag ends up set.
- R8: irq_o is 1 exactly when some flag bit and the matching mask bit are both 1.
- R9: When clr_i is 1, both digits become 0 at that edge. A tick in the same cycle is dropped: the count does not advance and no flag is set. The flags are otherwise unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 100 Hz tick pulse, one cycle wide |
| clr_i | input | 1 | Synchronous counter clear |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational from bus_addr_i |
| irq_o | output | 1 | Interrupt request |

## Verification
Tick, clear and register writes all act at one clock edge. The count, the flags, the mask and irq_o are therefore due in the cycle that follows that stimulus. bus_rdata_o is due in the same cycle that the address is presented. The driver applies each stimulus just after a falling edge and updates its reference model at that same step. The monitor compares the values it pops from the queue only at the next falling edge, after exactly one rising edge has gone by.

// File: rtl/swt_pkg.sv
package swt_pkg;
  localparam int DIGIT_W    = 4;
  localparam int NUM_DIGITS = 2;
  localparam int NUM_RATES  = NUM_DIGITS + 1;
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 2;
  localparam logic [DIGIT_W-1:0] DIGIT_MAX = 4'd9;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_COUNT = 2'd0,
    ADDR_MASK  = 2'd1,
    ADDR_FLAG  = 2'd2,
    ADDR_RSVD  = 2'd3
  } reg_addr_e;

  // event index: 0 = 100 Hz, 1 = 10 Hz, 2 = 1 Hz
  localparam int RATE_100 = 0;
  localparam int RATE_10  = 1;
  localparam int RATE_1   = 2;
endpackage

// File: rtl/swt_bcd_digit.sv
module swt_bcd_digit
  import swt_pkg::*;
#(
  parameter int W = DIGIT_W,
  parameter logic [W-1:0] MAX = DIGIT_MAX
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] digit_o,
  output logic         wrap_o
);
  logic [W-1:0] digit_q;

  assign wrap_o  = inc_i && (digit_q == MAX);
  assign digit_o = digit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      digit_q <= '0;
    else if (clr_i)   digit_q <= '0;
    else if (wrap_o)  digit_q <= '0;
    else if (inc_i)   digit_q <= digit_q + 1'b1;
  end

  p_digit_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    digit_q <= MAX);
  p_wrap_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && digit_q == MAX) |=> digit_q == '0);
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !clr_i) |=> $stable(digit_q));
  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> digit_q == '0);
endmodule

// File: rtl/swt_bcd_counter.sv
module swt_bcd_counter
  import swt_pkg::*;
#(
  parameter int N = NUM_DIGITS,
  parameter int W = DIGIT_W,
  localparam int NE = N + 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tick_i,
  input  logic           clr_i,
  output logic [N*W-1:0] count_o,
  output logic [NE-1:0]  event_o
);
  logic [N:0] inc;

  // clear drops a coincident tick
  assign inc[0] = tick_i && !clr_i;

  for (genvar k = 0; k < N; k++) begin : g_digit
    swt_bcd_digit #(.W(W), .MAX(DIGIT_MAX)) u_digit (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr_i),
      .inc_i  (inc[k]),
      .digit_o(count_o[k*W +: W]),
      .wrap_o (inc[k+1])
    );
  end

  assign event_o = inc;
endmodule

// File: rtl/swt_irq_regs.sv
module swt_irq_regs
  import swt_pkg::*;
#(
  parameter int NR = NUM_RATES
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NR-1:0] event_i,
  input  logic          mask_we_i,
  input  logic          flag_we_i,
  input  logic [NR-1:0] wdata_i,
  output logic [NR-1:0] mask_o,
  output logic [NR-1:0] flag_o,
  output logic          irq_o
);
  logic [NR-1:0] mask_q;
  logic [NR-1:0] flag_q;
  logic [NR-1:0] w1c;

  assign w1c = flag_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '0;
    else if (mask_we_i) mask_q <= wdata_i;
  end

  for (genvar i = 0; i < NR; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         flag_q[i] <= 1'b0;
      else if (event_i[i]) flag_q[i] <= 1'b1;
      else if (w1c[i])     flag_q[i] <= 1'b0;
    end

    p_set_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      event_i[i] |=> flag_q[i]);
    p_w1c_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_we_i && wdata_i[i] && !event_i[i]) |=> !flag_q[i]);
    p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!event_i[i] && !(flag_we_i && wdata_i[i])) |=> $stable(flag_q[i]));
    p_irq_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[i] && mask_q[i]) |-> irq_o);
  end

  assign irq_o  = |(flag_q & mask_q);
  assign mask_o = mask_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/swt_stopwatch.sv
module swt_stopwatch
  import swt_pkg::*;
#(
  localparam int CNT_W = NUM_DIGITS * DIGIT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              clr_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);
  logic [CNT_W-1:0]     count;
  logic [NUM_RATES-1:0] events;
  logic [NUM_RATES-1:0] mask;
  logic [NUM_RATES-1:0] flag;
  reg_addr_e            addr;

  assign addr = reg_addr_e'(bus_addr_i);

  swt_bcd_counter #(.N(NUM_DIGITS), .W(DIGIT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .clr_i  (clr_i),
    .count_o(count),
    .event_o(events)
  );

  swt_irq_regs #(.NR(NUM_RATES)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .event_i  (events),
    .mask_we_i(bus_we_i && addr == ADDR_MASK),
    .flag_we_i(bus_we_i && addr == ADDR_FLAG),
    .wdata_i  (bus_wdata_i[NUM_RATES-1:0]),
    .mask_o   (mask),
    .flag_o   (flag),
    .irq_o    (irq_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    unique case (addr)
      ADDR_COUNT: bus_rdata_o[CNT_W-1:0]     = count;
      ADDR_MASK:  bus_rdata_o[NUM_RATES-1:0] = mask;
      ADDR_FLAG:  bus_rdata_o[NUM_RATES-1:0] = flag;
      default:    bus_rdata_o = '0;
    endcase
  end

  p_count_ro_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && addr == ADDR_COUNT && !tick_i && !clr_i) |=> $stable(count));
  p_tick_sets_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !clr_i) |=> flag[RATE_100]);
  p_clr_no_event_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !bus_we_i) |=> $stable(flag));
endmodule

// File: tb/sim_swt_stopwatch.sv
module sim_swt_stopwatch;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       clr_i = 1'b0;
  logic       bus_we_i = 1'b0;
  logic [1:0] bus_addr_i = 2'd0;
  logic [7:0] bus_wdata_i = 8'd0;
  logic [7:0] bus_rdata_o;
  logic       irq_o;

  always #2.5 clk_i = ~clk_i;

  swt_stopwatch u0 (.*);

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference model
  int m_h = 0, m_t = 0;
  logic [2:0] m_mask = '0, m_flag = '0;

  // scoreboard: bit 8 = 1 -> irq item, else rdata item
  logic [8:0] q_exp[$];
  string      q_tag[$];
  bit         pend = 1'b0;

  function automatic logic [7:0] model_rd(input logic [1:0] a);
    case (a)
      2'd0: return {4'(m_t), 4'(m_h)};
      2'd1: return {5'd0, m_mask};
      2'd2: return {5'd0, m_flag};
      default: return 8'd0;
    endcase
  endfunction

  // one clock edge with given inputs; model updated to post-edge state
  task automatic step(input bit tk, input bit cl, input bit we,
                      input logic [1:0] a, input logic [7:0] wd);
    logic [2:0] ev;
    tick_i = tk; clr_i = cl; bus_we_i = we; bus_addr_i = a; bus_wdata_i = wd;
    ev[0] = tk && !cl;
    ev[1] = ev[0] && m_h == 9;
    ev[2] = ev[1] && m_t == 9;
    if (we && a == 2'd2) m_flag = m_flag & ~wd[2:0];
    m_flag = m_flag | ev;
    if (we && a == 2'd1) m_mask = wd[2:0];
    if (cl) begin m_h = 0; m_t = 0; end
    else if (ev[0]) begin
      if (m_h == 9) begin m_h = 0; m_t = (m_t == 9) ? 0 : m_t + 1; end
      else m_h = m_h + 1;
    end
    @(negedge clk_i); #1;
    tick_i = 0; clr_i = 0; bus_we_i = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1, 0, 0, 2'd0, 8'd0);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    step(0, 0, 1, a, d);
  endtask

  task automatic check_rd(input logic [1:0] a, input string tag);
    bus_addr_i = a;
    q_exp.push_back({1'b0, model_rd(a)});
    q_tag.push_back(tag);
    pend = 1'b1;
    @(negedge clk_i); #1;
  endtask

  task automatic check_irq(input string tag);
    q_exp.push_back({1'b1, 7'd0, |(m_flag & m_mask)});
    q_tag.push_back(tag);
    pend = 1'b1;
    @(negedge clk_i); #1;
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (pend) begin
      logic [8:0] e;
      string t;
      logic [7:0] act;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      act = e[8] ? {7'd0, irq_o} : bus_rdata_o;
      checks++;
      if (act !== e[7:0]) begin
        failures++;
        $display("FAIL %s: actual=%02h expected=%02h", t, act, e[7:0]);
      end
      pend = 1'b0;
    end
  end

  initial begin
    #1;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    check_rd(2'd0, "R1 count reset");
    check_rd(2'd1, "R4 mask reset");
    check_rd(2'd2, "R5 flag reset");
    check_irq("R8 irq reset");
    wr(2'd1, 8'hFF);
    check_rd(2'd1, "R4 mask upper bits zero");
    check_rd(2'd3, "R4 reserved address");
    wr(2'd1, 8'h00);
    ticks(1);
    check_rd(2'd0, "R2 first tick");
    check_rd(2'd2, "R5 100Hz flag while masked");
    check_irq("R8 masked flag no irq");
    ticks(8);
    check_rd(2'd0, "R2 hundredths at 9");
    ticks(1);
    check_rd(2'd0, "R2 carry into tenths");
    check_rd(2'd2, "R5 10Hz flag");
    wr(2'd0, 8'h55);
    check_rd(2'd0, "R3 count write ignored");
    wr(2'd2, 8'hFA);
    check_rd(2'd2, "R6 w1c bit1");
    wr(2'd2, 8'h00);
    check_rd(2'd2, "R6 write zero keeps");
    wr(2'd1, 8'h01);
    check_irq("R8 irq asserted");
    wr(2'd2, 8'h01);
    check_irq("R8 irq dropped after clear");
    step(1, 0, 1, 2'd2, 8'h01);
    check_rd(2'd2, "R7 set beats clear");
    check_irq("R8 irq after set-wins");
    wr(2'd2, 8'h07);
    wr(2'd1, 8'h04);
    while (!(m_h == 9 && m_t == 9)) ticks(1);
    check_rd(2'd0, "R2 at 99");
    check_irq("R8 no 1Hz yet");
    ticks(1);
    check_rd(2'd0, "R2 wrap to 00");
    check_rd(2'd2, "R5 all three flags");
    check_irq("R8 1Hz irq");
    ticks(23);
    wr(2'd2, 8'h07);
    step(1, 1, 0, 2'd0, 8'd0);
    check_rd(2'd0, "R9 clear zeroes count");
    check_rd(2'd2, "R9 clear drops tick events");
    ticks(1);
    step(0, 1, 0, 2'd0, 8'd0);
    check_rd(2'd2, "R9 flags kept over clear");
    check_rd(2'd0, "R9 count zero after clear");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5 * 20000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule